// File: doc/BRIEF.md
# Programmable Streaming CRC Engine

This block computes a CRC of up to 32 bits over a byte stream, one byte per clock. The polynomial, initial value, output width (8, 16 or 32 bits), final XOR value and input bit order are not fixed in hardware. They are held in two independent definition sets that are loaded through a simple register write port. Each message picks one of the two sets on its first byte.

A narrow CRC is kept left-aligned in the 32-bit state, so that its most significant bit sits at bit 31. Any width that is not 8, 16 or 32 is programmed as the next larger field, with the definition placed in the upper bits. While a message is running, the raw state can be read at any time. On the last byte, the state is XORed with the final value and presented as four bytes in memory order. Each of those bytes can optionally be bit-reversed.

Top module: `crc_stream_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `partial` is zero and `res_valid` is low. `s_ready` is high from the second clock after reset is released.
- R2: A write with `cfg_we` high stores `cfg_wdata` into set `cfg_set`. The target field is chosen by `cfg_addr`: 0 = initial value, 1 = polynomial, 2 = final XOR, 3 = control. In the control word, bits [1:0] are the width code and bit 2 is the bit-order flag.
- R3: A beat with `s_start` high loads the state from the initial value of set `s_set` and processes that beat's byte. The selected set is held for the whole message. `s_set` on beats without `s_start` has no effect.
- R4: Each accepted beat (`s_valid` and `s_ready`) advances the state by eight shift/XOR steps on the left-aligned 32-bit state. The new state appears on `partial` one clock after the beat.
- R5: With the bit-order flag at 1, each byte enters the computation from bit 7 down to bit 0. With the flag at 0, it enters from bit 0 up to bit 7.
- R6: Width code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Bits of the initial value, polynomial and final XOR that lie below the selected width are ignored. The same low bits of `partial` always read zero.
- R7: On a beat with `s_last` high, `res_valid` is high for the following cycle only. It is high in no other cycle.
- R8: The result is the final state XORed with the final XOR value. Memory offset k (k = 0..3) is carried in `res_mem[8k+7:8k]` and holds result bits [31-8k:24-8k]. Offset 0 therefore carries the highest byte.
- R9: When `s_swap` is high on the last beat, each of the four output bytes is bit-reversed in place.
- R10: While `s_valid` is low, the state does not change, whatever `s_data`, `s_start` and `s_last` carry.
- R11: The two definition sets are independent. Writing one set does not change a result computed with the other.
- R12: A start beat in the middle of a message discards the running state and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Definition register write strobe |
| cfg_set | input | 1 | Definition set written |
| cfg_addr | input | 2 | Field written (init, poly, xor, control) |
| cfg_wdata | input | 32 | Write data |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Engine accepts bytes |
| s_data | input | 8 | Input byte |
| s_start | input | 1 | First byte of a message |
| s_last | input | 1 | Last byte of a message |
| s_set | input | 1 | Definition set for the message (used on start beat) |
| s_swap | input | 1 | Bit-reverse each output byte (used on last beat) |
| partial | output | 32 | Current un-XORed state, left-aligned |
| res_valid | output | 1 | Result valid pulse |
| res_mem | output | 32 | Result bytes, offset k in bits [8k+7:8k] |

## Verification
Both outputs have a single-register latency. `partial` shows a beat's effect, and `res_valid` with `res_mem` shows a final beat's result, in the cycle right after the clock edge that accepted the beat. The bench drives each beat on a falling edge and reads the outputs on the next falling edge, which is exactly one register stage later. One falling edge after that, it confirms that `res_valid` has dropped again. Register writes take effect at the clock edge of the write, so the bench lets each write finish before it sends bytes.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    WSEL_8   = 2'd0,
    WSEL_16  = 2'd1,
    WSEL_32  = 2'd2,
    WSEL_32B = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    REG_INIT = 2'd0,
    REG_POLY = 2'd1,
    REG_XOR  = 2'd2,
    REG_CTRL = 2'd3
  } reg_e;

  typedef struct packed {
    logic [CRC_W-1:0] init;
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] fxor;
    wsel_e            wsel;
    logic             msb_first;
  } crc_def_t;

  // Left-aligned mask of the live CRC bits for a width code.
  function automatic logic [CRC_W-1:0] width_mask(wsel_e w);
    logic [CRC_W-1:0] all1;
    all1 = '1;
    case (w)
      WSEL_8:  return ~(all1 >> 8);
      WSEL_16: return ~(all1 >> 16);
      default: return all1;
    endcase
  endfunction
endpackage

// File: rtl/crc_def_bank.sv
module crc_def_bank
  import crc_pkg::*;
#(
  parameter int unsigned NUM_SETS = 2,
  parameter int unsigned SET_BITS = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [SET_BITS-1:0] wset,
  input  logic [1:0]          waddr,
  input  logic [CRC_W-1:0]    wdata,
  input  logic [SET_BITS-1:0] rd_sel,
  output crc_def_t            rd_def
);
  crc_def_t defs [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) defs[s] <= '0;
    end else if (we) begin
      case (reg_e'(waddr))
        REG_INIT: defs[wset].init <= wdata;
        REG_POLY: defs[wset].poly <= wdata;
        REG_XOR:  defs[wset].fxor <= wdata;
        REG_CTRL: begin
          defs[wset].wsel      <= wsel_e'(wdata[1:0]);
          defs[wset].msb_first <= wdata[2];
        end
        default: ;
      endcase
    end
  end

  assign rd_def = defs[rd_sel];

  // R2: an init write to set 0 is held by the bank on the next cycle
  p_cfg_init_r2: assert property (@(posedge clk) disable iff (rst)
    (we && wset == '0 && waddr == 2'd0) |=> (defs[0].init == $past(wdata)));
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [CRC_W-1:0]  state_in,
  input  logic [CRC_W-1:0]  poly,
  input  logic [CRC_W-1:0]  mask,
  input  logic [BYTE_W-1:0] data,
  input  logic              msb_first,
  output logic [CRC_W-1:0]  state_out
);
  logic [CRC_W-1:0] chain [0:BYTE_W];
  logic [CRC_W-1:0] pmask;

  assign pmask    = poly & mask;
  assign chain[0] = state_in & mask;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic             din;
    logic             fb;
    logic [CRC_W-1:0] sh;
    assign din          = msb_first ? data[BYTE_W-1-i] : data[i];
    assign fb           = chain[i][CRC_W-1] ^ din;
    assign sh           = {chain[i][CRC_W-2:0], 1'b0};
    assign chain[i+1]   = fb ? (sh ^ pmask) : sh;
  end

  assign state_out = chain[BYTE_W];
endmodule

// File: rtl/crc_out_format.sv
module crc_out_format #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CRC_W-1:0] state,
  input  logic [CRC_W-1:0] fxor,
  input  logic [CRC_W-1:0] mask,
  input  logic             swap,
  output logic             res_valid,
  output logic [CRC_W-1:0] res_mem
);
  localparam int unsigned NB = CRC_W / BYTE_W;

  logic [CRC_W-1:0] fin;
  logic [CRC_W-1:0] laid;

  assign fin = (state ^ fxor) & mask;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] rev;
    assign src = fin[CRC_W-1-k*BYTE_W -: BYTE_W];
    for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
      assign rev[b] = src[BYTE_W-1-b];
    end
    assign laid[k*BYTE_W +: BYTE_W] = swap ? rev : src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_mem   <= '0;
    end else begin
      res_valid <= fire;
      if (fire) res_mem <= laid;
    end
  end

  // R7: a result only ever follows a final beat
  p_res_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(fire));
endmodule

// File: rtl/crc_stream_engine.sv
module crc_stream_engine
  import crc_pkg::*;
#(
  parameter int unsigned NUM_SETS = 2,
  parameter int unsigned SET_BITS = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [SET_BITS-1:0] cfg_set,
  input  logic [1:0]          cfg_addr,
  input  logic [CRC_W-1:0]    cfg_wdata,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [BYTE_W-1:0]   s_data,
  input  logic                s_start,
  input  logic                s_last,
  input  logic [SET_BITS-1:0] s_set,
  input  logic                s_swap,
  output logic [CRC_W-1:0]    partial,
  output logic                res_valid,
  output logic [CRC_W-1:0]    res_mem
);
  logic                ready_q;
  logic [CRC_W-1:0]    state_q;
  logic [CRC_W-1:0]    mask_q;
  logic [SET_BITS-1:0] act_set_q;
  logic [SET_BITS-1:0] cur_set;
  logic                beat;
  crc_def_t            cur_def;
  logic [CRC_W-1:0]    cur_mask;
  logic [CRC_W-1:0]    step_in;
  logic [CRC_W-1:0]    step_out;

  assign beat     = s_valid & ready_q;
  assign cur_set  = s_start ? s_set : act_set_q;
  assign cur_mask = width_mask(cur_def.wsel);
  assign step_in  = s_start ? cur_def.init : state_q;

  crc_def_bank #(.NUM_SETS(NUM_SETS), .SET_BITS(SET_BITS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wset   (cfg_set),
    .waddr  (cfg_addr),
    .wdata  (cfg_wdata),
    .rd_sel (cur_set),
    .rd_def (cur_def)
  );

  crc_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_step (
    .state_in  (step_in),
    .poly      (cur_def.poly),
    .mask      (cur_mask),
    .data      (s_data),
    .msb_first (cur_def.msb_first),
    .state_out (step_out)
  );

  crc_out_format #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_fmt (
    .clk       (clk),
    .rst       (rst),
    .fire      (beat & s_last),
    .state     (step_out),
    .fxor      (cur_def.fxor),
    .mask      (cur_mask),
    .swap      (s_swap),
    .res_valid (res_valid),
    .res_mem   (res_mem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      state_q   <= '0;
      mask_q    <= '0;
      act_set_q <= '0;
    end else begin
      ready_q <= 1'b1;
      if (beat) begin
        state_q <= step_out;
        mask_q  <= cur_mask;
        if (s_start) act_set_q <= s_set;
      end
    end
  end

  assign s_ready = ready_q;
  assign partial = state_q;

  // R1: ready once a full cycle out of reset
  p_ready_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> s_ready);

  // R10: no accepted beat, no state change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> $stable(partial));

  // R6: bits below the active width stay clear
  p_lowbits_r6: assert property (@(posedge clk) disable iff (rst)
    (partial & ~mask_q) == '0);
endmodule

// File: tb/tb_crc_stream_engine.sv
module tb_crc_stream_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_set = '0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_start = 1'b0;
  logic        s_last = 1'b0;
  logic [0:0]  s_set = '0;
  logic        s_swap = 1'b0;
  logic [31:0] partial;
  logic        res_valid;
  logic [31:0] res_mem;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crc_stream_engine dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_start(s_start), .s_last(s_last), .s_set(s_set), .s_swap(s_swap),
    .partial(partial), .res_valid(res_valid), .res_mem(res_mem)
  );

  typedef struct packed {
    logic        set;
    logic [1:0]  w;
    logic [31:0] poly;
    logic [31:0] init;
    logic [31:0] fxor;
    logic        msbf;
    logic        swap;
    logic [31:0] exp;
  } vec_t;

  // Published check values for the message "123456789"
  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd2, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h181989FC},
    '{1'b1, 2'd2, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 32'hCBF43926},
    '{1'b0, 2'd1, 32'h10210000, 32'hFFFF0000, 32'h00000000, 1'b1, 1'b0, 32'h0000B129},
    '{1'b1, 2'd1, 32'h10210000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 32'h0000C331},
    '{1'b0, 2'd0, 32'h07000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 32'h000000F4},
    '{1'b1, 2'd0, 32'h07000000, 32'h00000000, 32'h00000000, 1'b1, 1'b1, 32'h0000002F},
    '{1'b0, 2'd2, 32'h04C11DB7, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 32'hE7E67603},
    '{1'b1, 2'd1, 32'h80050000, 32'h00000000, 32'h00000000, 1'b0, 1'b1, 32'h0000BB3D}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic set, input logic [1:0] addr, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = set; cfg_addr = addr; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_def(input logic set, input logic [1:0] w, input logic [31:0] poly,
                          input logic [31:0] init, input logic [31:0] fxor, input logic msbf);
    cfg_write(set, 2'd0, init);
    cfg_write(set, 2'd1, poly);
    cfg_write(set, 2'd2, fxor);
    cfg_write(set, 2'd3, {29'd0, msbf, w});
  endtask

  // Called at a falling edge; returns at the falling edge after the beat's clock edge.
  task automatic send_byte(input logic [7:0] d, input logic st, input logic lst,
                           input logic set, input logic swp);
    s_valid = 1'b1; s_data = d; s_start = st; s_last = lst; s_set = set; s_swap = swp;
    @(negedge clk);
    s_valid = 1'b0; s_start = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_msg(input logic set, input logic swp, input logic flip,
                          input logic [31:0] exp, input string req);
    @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      send_byte(8'h31 + 8'(i), i == 0, i == 8, (i != 0 && flip) ? ~set : set, swp);
    end
    check({req, " result value"}, res_mem, exp);
    check("R7 result valid after last", {31'd0, res_valid}, 32'd1);
    @(negedge clk);
    check("R7 result valid single cycle", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 partial in reset", partial, 32'h0);
    check("R1 res_valid in reset", {31'd0, res_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 partial after reset", partial, 32'h0);
    @(negedge clk);
    check("R1 ready", {31'd0, s_ready}, 32'd1);

    // Table walk: R2 R5 R6 R8 R9 across widths, orders and swap
    for (int i = 0; i < 8; i++) begin
      load_def(VECS[i].set, VECS[i].w, VECS[i].poly, VECS[i].init, VECS[i].fxor, VECS[i].msbf);
      send_msg(VECS[i].set, VECS[i].swap, 1'b0, VECS[i].exp, "R8 R9 table");
    end

    // R4: one byte 0x01, CRC-8 poly 0x07, bit 7 first -> 0x07 left-aligned
    load_def(1'b0, 2'd0, 32'h07000000, 32'h0, 32'h0, 1'b1);
    @(negedge clk);
    send_byte(8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 partial after one byte", partial, 32'h07000000);
    // R5: same byte, bit 0 first -> 0x89
    cfg_write(1'b0, 2'd3, 32'h0);
    @(negedge clk);
    send_byte(8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 partial bit0 first", partial, 32'h89000000);

    // R10: invalid cycles with busy data lines
    s_data = 8'hFF; s_start = 1'b1; s_last = 1'b1; s_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 partial held", partial, 32'h89000000);
    check("R10 no result", {31'd0, res_valid}, 32'd0);
    s_start = 1'b0; s_last = 1'b0;

    // R6: garbage in the unused low bits of an 8-bit definition
    load_def(1'b0, 2'd0, 32'h07123456, 32'h00ABCDEF, 32'h00FFFFFF, 1'b1);
    @(negedge clk);
    send_byte(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 low bits of partial zero", partial & 32'h00FFFFFF, 32'h0);
    // R12: the unfinished message above is dropped by a new start
    send_byte(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
    send_msg(1'b0, 1'b0, 1'b0, 32'h000000F4, "R6 R12 masked restart");

    // R11: two sets loaded, used alternately
    load_def(1'b0, 2'd2, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    load_def(1'b1, 2'd1, 32'h10210000, 32'h0, 32'h0, 1'b1);
    send_msg(1'b1, 1'b0, 1'b0, 32'h0000C331, "R11 set1");
    send_msg(1'b0, 1'b0, 1'b0, 32'h181989FC, "R11 set0");

    // R3: select toggled on non-start beats is ignored
    send_msg(1'b0, 1'b0, 1'b1, 32'h181989FC, "R3 select held");
    send_msg(1'b1, 1'b0, 1'b1, 32'h0000C331, "R3 select held set1");

    // R6: width code 3 acts as 32 bits
    load_def(1'b1, 2'd3, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    send_msg(1'b1, 1'b0, 1'b0, 32'h181989FC, "R6 width code 3");

    // R7: back-to-back one-byte messages, CRC-8 of 0x01 = 0x07
    load_def(1'b0, 2'd0, 32'h07000000, 32'h0, 32'h0, 1'b1);
    @(negedge clk);
    send_byte(8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 single-byte result", res_mem, 32'h00000007);
    check("R7 valid first", {31'd0, res_valid}, 32'd1);
    send_byte(8'h01, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R9 single-byte swapped", res_mem, 32'h000000E0);
    check("R7 valid second", {31'd0, res_valid}, 32'd1);
    @(negedge clk);
    check("R7 valid drops", {31'd0, res_valid}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule